// File: doc/BRIEF.md
# Round-Robin Warp Issue Scheduler with Memory-Stall Tracking

This block picks which warp issues an instruction on each clock. It serves a fixed pool of resident warp slots: the total slot count divided by the number of schedulers, with one instance built for each scheduler. A warp can be picked when three things hold. Its instruction is available, it is launched, and it is not waiting on a long-latency memory load. Among the warps that can be picked, a rotating pointer gives first priority to the slot after the warp that issued last. Every waiting warp is therefore reached within one lap of the pool.

When the issued instruction is a global memory load, the issuing warp is parked. A per-warp countdown is loaded with the modelled memory latency. The warp becomes selectable again when the countdown expires, or earlier if a load-return event for that warp arrives. Warp state never leaves the slot, so the pick moves to another ready warp in the very next cycle with no switch penalty. Long memory waits are hidden whenever enough warps are ready.

The issue output is a plain strobe with a warp ID. The downstream dispatch path always accepts it and applies no back-pressure. In a cycle where no warp is ready, the strobe stays low and forms a bubble.

Top module: `warp_sched`

## Requirements
- R1: A warp is eligible only when its `warp_valid` bit is 1, its `warp_active` bit is 1, and it is not stalled. `issue_vld` is 1 only for an eligible warp.
- R2: The search begins at the slot after the warp that issued last and wraps around the pool. After reset the pointer holds the last slot, so warp 0 has first priority.
- R3: When no warp is eligible, `issue_vld` is 0 and the priority pointer keeps its value.
- R4: When `ld_issue` is 1 in a cycle where `issue_vld` is 1, the warp `issue_wid` is stalled for exactly `LOAD_LAT` cycles after that cycle. It is selectable again in the following cycle.
- R5: `issue_vld` is 1 in every cycle in which at least one warp is eligible, including the cycle right after another warp stalled. The warp switch costs no cycle.
- R6: `ld_issue` has no effect in a cycle where `issue_vld` is 0.
- R7: When `ld_ret_vld` is 1, the stall of warp `ld_ret_wid` ends at the next clock edge, and the warp is selectable in the next cycle.
- R8: If a new load issue and a return for the same warp fall in the same cycle, the new load wins and the warp becomes stalled.
- R9: A warp whose `warp_active` bit is 0 is never selected, whatever its `warp_valid` bit is.
- R10: The pool holds N = `TOTAL_SLOTS`/`NUM_SCHED` warps with IDs 0 to N-1. `issue_wid` stays below N, and the rotation wraps from N-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid | input | N | Per-warp flag: an instruction is available to issue |
| warp_active | input | N | Per-warp flag: the warp is launched and has not exited |
| ld_issue | input | 1 | The instruction issued this cycle is a long-latency load |
| ld_ret_vld | input | 1 | A load return event for one warp |
| ld_ret_wid | input | clog2(N) | Warp ID of the load return |
| issue_vld | output | 1 | An instruction issues this cycle |
| issue_wid | output | clog2(N) | Warp ID selected this cycle |

## Verification
The assertions take for granted that every input is known after reset and that `ld_ret_wid` names a slot inside the pool whenever `ld_ret_vld` is 1. The round-robin and stall properties also assume that the flag inputs change only between clock edges. The bench drives all inputs at the falling edge and uses only IDs 0 to 3 in a four-warp pool. It sends returns only to real slots, so the stimulus stays inside these assumptions throughout.

// File: rtl/ws_pkg.sv
package ws_pkg;
  // Slot index reached by stepping 'step' places past 'base' in a ring of 'n'.
  function automatic int ring_step(input int base, input int step, input int n);
    return (base + step) % n;
  endfunction
endpackage

// File: rtl/ws_stall_timer.sv
module ws_stall_timer #(
  parameter int LOAD_LAT = 600,
  localparam int CW = $clog2(LOAD_LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_go,
  input  logic load_back,
  output logic stalled
);
  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load_go) begin
      remain_q <= CW'(LOAD_LAT);
    end else if (load_back) begin
      remain_q <= '0;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - CW'(1);
    end
  end

  assign stalled = (remain_q != '0);

  // R4 and R8: a new load parks the warp, even when a return arrives in the same cycle
  p_load_parks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> stalled);
  // R7: a return without a new load releases the warp
  p_return_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_back && !load_go) |=> !stalled);
  // R4: an idle warp stays free until a load arrives
  p_idle_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stalled && !load_go) |=> !stalled);
endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick
  import ws_pkg::*;
#(
  parameter int N  = 12,
  parameter int IW = 4
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] last_id,
  output logic          grant_vld,
  output logic [IW-1:0] grant_id
);
  always_comb begin
    grant_vld = 1'b0;
    grant_id  = '0;
    // Walk from farthest to nearest so that the nearest eligible slot wins.
    for (int k = N; k >= 1; k--) begin
      if (elig[ring_step(int'(last_id), k, N)]) begin
        grant_vld = 1'b1;
        grant_id  = IW'(ring_step(int'(last_id), k, N));
      end
    end
  end
endmodule

// File: rtl/warp_sched.sv
module warp_sched #(
  parameter int TOTAL_SLOTS = 48,
  parameter int NUM_SCHED   = 4,
  parameter int LOAD_LAT    = 600,
  localparam int N  = TOTAL_SLOTS / NUM_SCHED,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  warp_valid,
  input  logic [N-1:0]  warp_active,
  input  logic          ld_issue,
  input  logic          ld_ret_vld,
  input  logic [IW-1:0] ld_ret_wid,
  output logic          issue_vld,
  output logic [IW-1:0] issue_wid
);
  logic [N-1:0]  parked;
  logic [N-1:0]  elig;
  logic [IW-1:0] last_q;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic go_w, back_w;
    assign go_w   = issue_vld && ld_issue && (issue_wid == IW'(g));
    assign back_w = ld_ret_vld && (ld_ret_wid == IW'(g));
    ws_stall_timer #(.LOAD_LAT(LOAD_LAT)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_go   (go_w),
      .load_back (back_w),
      .stalled   (parked[g])
    );
  end

  assign elig = warp_valid & warp_active & ~parked;

  ws_rr_pick #(.N(N), .IW(IW)) u_pick (
    .elig      (elig),
    .last_id   (last_q),
    .grant_vld (issue_vld),
    .grant_id  (issue_wid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= IW'(N - 1);
    end else if (issue_vld) begin
      last_q <= issue_wid;
    end
  end

  // R1: only an eligible warp issues
  p_pick_eligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> (warp_valid[issue_wid] && !parked[issue_wid]));
  // R9: an inactive warp is never picked
  p_inactive_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> warp_active[issue_wid]);
  // R5: any eligible warp means an issue in this cycle
  p_no_lost_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (elig != '0) |-> issue_vld);
  // R3: a bubble only when nothing is eligible, and the pointer holds
  p_bubble_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> $stable(last_q));
  // R2: the last issuer is repicked only when it is the sole candidate
  p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(elig) > 1) |-> (issue_wid != last_q));
  // R10: the issued ID lies inside the pool
  p_id_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> (int'(issue_wid) < N));
  // R4: a load issue parks the issuing warp on the next cycle
  p_load_parks_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && ld_issue) |=> parked[$past(issue_wid)]);
endmodule

// File: tb/warp_sched_tb.sv
module warp_sched_tb;
  localparam int TOT = 16;
  localparam int NS  = 4;
  localparam int LAT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] warp_valid = '0;
  logic [3:0] warp_active = '0;
  logic       ld_issue = 1'b0;
  logic       ld_ret_vld = 1'b0;
  logic [1:0] ld_ret_wid = '0;
  logic       issue_vld;
  logic [1:0] issue_wid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  warp_sched #(.TOTAL_SLOTS(TOT), .NUM_SCHED(NS), .LOAD_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .warp_active(warp_active),
    .ld_issue(ld_issue), .ld_ret_vld(ld_ret_vld), .ld_ret_wid(ld_ret_wid),
    .issue_vld(issue_vld), .issue_wid(issue_wid)
  );

  // Row layout: {valid[3:0], active[3:0], ld_issue, exp_vld, exp_wid[1:0]}.
  // Warps use LAT=5: a load in cycle t parks the warp in cycles t+1..t+5.
  localparam logic [11:0] TBL [25] = '{
    {4'hF, 4'hF, 1'b0, 1'b1, 2'd0},  // R2 reset priority: warp 0 first
    {4'hF, 4'hF, 1'b1, 1'b1, 2'd1},  // warp 1 issues a load
    {4'hF, 4'hF, 1'b0, 1'b1, 2'd2},  // R5 switch at once
    {4'hF, 4'hF, 1'b0, 1'b1, 2'd3},
    {4'hF, 4'hF, 1'b0, 1'b1, 2'd0},  // R10 wrap 3 -> 0
    {4'hF, 4'hF, 1'b1, 1'b1, 2'd2},  // R4 warp 1 skipped, warp 2 loads
    {4'hF, 4'hF, 1'b0, 1'b1, 2'd3},
    {4'hF, 4'hF, 1'b0, 1'b1, 2'd0},
    {4'hF, 4'hF, 1'b0, 1'b1, 2'd1},  // R4 warp 1 back after LAT cycles
    {4'hF, 4'hB, 1'b0, 1'b1, 2'd3},  // R9 warp 2 inactive
    {4'h5, 4'hF, 1'b0, 1'b1, 2'd0},  // R1 only valid warps
    {4'h4, 4'hF, 1'b0, 1'b1, 2'd2},  // R4 warp 2 free again
    {4'h0, 4'hF, 1'b0, 1'b0, 2'd0},  // R3 bubble, nothing valid
    {4'hF, 4'h0, 1'b0, 1'b0, 2'd0},  // R9 bubble, nothing active
    {4'hF, 4'hF, 1'b0, 1'b1, 2'd3},  // R3 pointer held over bubbles
    {4'hA, 4'hF, 1'b0, 1'b1, 2'd1},
    {4'hA, 4'hF, 1'b0, 1'b1, 2'd3},  // R2 rotation among 1 and 3
    {4'hF, 4'hF, 1'b1, 1'b1, 2'd0},
    {4'hF, 4'hF, 1'b1, 1'b1, 2'd1},
    {4'hF, 4'hF, 1'b1, 1'b1, 2'd2},
    {4'hF, 4'hF, 1'b1, 1'b1, 2'd3},  // all four warps parked
    {4'hF, 4'hF, 1'b0, 1'b0, 2'd0},  // R4 bubble, all stalled
    {4'hF, 4'hF, 1'b1, 1'b0, 2'd0},  // R6 load flag during bubble, last stalled cycle of warp 0
    {4'hF, 4'hF, 1'b0, 1'b1, 2'd0},  // R6 warp 0 not re-parked
    {4'hF, 4'hF, 1'b0, 1'b1, 2'd1}
  };

  task automatic step(input logic [3:0] v, input logic [3:0] a, input logic ld,
                      input logic rv, input logic [1:0] rw,
                      input logic ev, input logic [1:0] ew, input string tag);
    @(negedge clk);
    warp_valid = v; warp_active = a; ld_issue = ld;
    ld_ret_vld = rv; ld_ret_wid = rw;
    #1;
    checks++;
    if (issue_vld !== ev || (ev && issue_wid !== ew)) begin
      errors++;
      $display("FAIL %s: got vld=%0b wid=%0d, expected vld=%0b wid=%0d",
               tag, issue_vld, issue_wid, ev, ew);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; warp_valid = '0; warp_active = '0; ld_issue = 1'b0; ld_ret_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < 25; i++) begin
      logic [11:0] r;
      r = TBL[i];
      step(r[11:8], r[7:4], r[3], 1'b0, 2'd0, r[2], r[1:0], $sformatf("row %0d R1-path", i));
    end

    // Return event cuts a stall short; reset priority again
    do_reset();
    step(4'hF, 4'hF, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, "R2 reset state picks warp 0");
    step(4'hF, 4'hF, 1'b0, 1'b0, 2'd0, 1'b1, 2'd1, "R5 zero-cost switch");
    step(4'hF, 4'hF, 1'b0, 1'b1, 2'd0, 1'b1, 2'd2, "R7 return sent for warp 0");
    step(4'hF, 4'hF, 1'b0, 1'b0, 2'd0, 1'b1, 2'd3, "R10 last slot");
    step(4'hF, 4'hF, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0, "R7 warp 0 freed early");
    // New load and return on the same warp in one cycle
    step(4'hF, 4'hF, 1'b1, 1'b1, 2'd1, 1'b1, 2'd1, "R8 warp 1 load plus return");
    step(4'h2, 4'hF, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, "R8 warp 1 still parked");
    // An inactive but valid warp alone yields a bubble
    step(4'h1, 4'h2, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, "R9 valid but inactive");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule